// File: doc/BRIEF.md
# Sequential Signed Recoding Multiplier

This unit multiplies a 32-bit two's-complement multiplicand by the low n bits of a multiplier word. It scans the multiplier one bit at a time, from least significant upward. At each step it pairs the current bit with the bit seen at the step before, and from that pair it adds the multiplicand into an accumulator, subtracts it, or does nothing. Between steps the accumulator and the multiplier register shift right together as one double-length register. The result is left split across two words: the accumulator holds the upper product bits and the multiplier register holds the lower ones.

The multiplicand is not held inside the unit. It arrives over a request/valid handshake from a word store, which could deliver any word of a track. The unit asks for the operand only on steps that add or subtract, and it waits for as long as the operand is late. Every clock stands for one word period of that store. A step that neither adds nor subtracts costs exactly one clock.

The step count comes from a 6-bit field that holds 33 − n. The counter counts upward, and the run stops on the step that sees counter bit 5 set.

The controller has four states: `S_IDLE`, `S_SCAN`, `S_FETCH` and `S_DONE`. Its transitions are:
- T_START: `S_IDLE`→`S_SCAN` on start.
- T_SKIP: `S_SCAN`→`S_SCAN` on an equal pair when the counter is not at its end.
- T_NEED: `S_SCAN`→`S_FETCH` on an unequal pair.
- T_STALL: `S_FETCH`→`S_FETCH` while the operand is not valid.
- T_APPLY: `S_FETCH`→`S_SCAN` when the operand is valid and the counter is not at its end.
- T_FINISH: `S_SCAN`/`S_FETCH`→`S_DONE` on the step where the counter is at its end.
- T_RETURN: `S_DONE`→`S_IDLE`.

Top module: `srm_mul`

## Requirements
- R1: After reset, acc_out and rq_out are zero and done and op_req are low.
- R2: Start in idle clears the accumulator, loads the multiplier register from mult_in, loads the counter from count_in and clears the remembered bit. mult_in and count_in are not looked at again during the run.
- R3: Each step takes the pair (remembered bit, rq bit 0). Pair (1,0) adds the multiplicand to the accumulator, pair (0,1) subtracts it, and pairs (0,0) and (1,1) leave the accumulator unchanged.
- R4: op_req is raised only for steps whose pair is unequal. A step with an equal pair takes one clock and raises no request. The run therefore lasts n clocks plus one clock, plus any stall, for each unequal pair.
- R5: While op_req is high and mcand_valid is low, op_req stays high and acc_out and rq_out hold their values.
- R6: After its add or subtract, a step with counter bit 5 clear adds one to the counter and shifts {acc, rq} right arithmetically. The accumulator's bit 0 enters rq bit 31, and the bit leaving rq bit 0 becomes the remembered bit.
- R7: A count field of 1 gives a full 32-bit multiply. Let P be the 64-bit product. Then acc_out = P[62:31], rq_out[31:1] = P[30:0], and rq_out[0] holds the original multiplier bit 31. The multiplicand 0x80000000 is outside the supported range.
- R8: A count field c in 1..32 gives n = 33 − c, and P = multiplicand × (signed low n bits of the multiplier). The result is acc_out = P >>> (n−1), and rq_out = {P[n−2:0], original multiplier[31:n−1]}.
- R9: A count field with bit 5 set runs a single step with no shift, acting as n = 1.
- R10: done is high for exactly one clock at the end of a run, and acc_out and rq_out hold their values after done until the next start.
- R11: Start asserted while a run is in progress has no effect on that run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Word-period clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a multiply (taken only when idle) |
| mult_in | input | 32 | Multiplier word loaded into the multiplier register |
| count_in | input | 6 | Step-count field, 33 − n |
| mcand | input | 32 | Multiplicand word from the store |
| mcand_valid | input | 1 | Multiplicand word is present this clock |
| op_req | output | 1 | Operand wanted for an add or subtract step |
| acc_out | output | 32 | Accumulator (upper product bits) |
| rq_out | output | 32 | Multiplier register (lower product bits) |
| done | output | 1 | One-clock end-of-run pulse |

## Verification
The checker watches every step and every clock. It checks the load on start, that equal pairs raise no request and unequal pairs do, the exact right-shift of a skip step, termination on counter bit 5, holding under stall, and the shape of the done pulse and the hold after it. Only the bench scenarios can show that the add/subtract recoding produces the correct signed product for each n. They also show that the total clock count matches n plus the fetched steps and stalls, that inputs changed after start are ignored, and that a second start mid-run leaves the result untouched.

// File: rtl/srm_pkg.sv
package srm_pkg;

    typedef enum logic [1:0] {
        S_IDLE,
        S_SCAN,
        S_FETCH,
        S_DONE
    } srm_state_t;

    typedef enum logic [1:0] {
        OP_NONE,
        OP_ADD,
        OP_SUB
    } srm_op_t;

endpackage

// File: rtl/srm_recode.sv
module srm_recode
    import srm_pkg::*;
(
    input  logic    prev_bit,
    input  logic    cur_bit,
    output srm_op_t op
);

    // A 1->0 transition going upward ends a run of ones (add).
    // A 0->1 transition starts a run of ones (subtract).
    always_comb begin
        unique case ({prev_bit, cur_bit})
            2'b10:   op = OP_ADD;
            2'b01:   op = OP_SUB;
            default: op = OP_NONE;
        endcase
    end

endmodule

// File: rtl/srm_step.sv
module srm_step
    import srm_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [W-1:0] acc,
    input  logic [W-1:0] rq,
    input  logic [W-1:0] mcand,
    input  srm_op_t      op,
    input  logic         shift_en,
    output logic [W-1:0] acc_nx,
    output logic [W-1:0] rq_nx,
    output logic         prev_nx
);

    logic [W-1:0] sum;

    always_comb begin
        unique case (op)
            OP_ADD:  sum = acc + mcand;
            OP_SUB:  sum = acc - mcand;
            default: sum = acc;
        endcase
        if (shift_en) begin
            acc_nx = {sum[W-1], sum[W-1:1]};
            rq_nx  = {sum[0], rq[W-1:1]};
        end else begin
            acc_nx = sum;
            rq_nx  = rq;
        end
        prev_nx = rq[0];
    end

endmodule

// File: rtl/srm_mul.sv
module srm_mul
    import srm_pkg::*;
#(
    parameter int W  = 32,
    parameter int CW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [W-1:0]  mult_in,
    input  logic [CW-1:0] count_in,
    input  logic [W-1:0]  mcand,
    input  logic          mcand_valid,
    output logic          op_req,
    output logic [W-1:0]  acc_out,
    output logic [W-1:0]  rq_out,
    output logic          done
);

    localparam int END_BIT = CW - 1;

    srm_state_t    st, st_nx;
    logic [W-1:0]  acc, rq;
    logic [CW-1:0] cnt;
    logic          prev;

    srm_op_t       op;
    logic [W-1:0]  acc_n, rq_n;
    logic          prev_n;
    logic          last, apply;

    assign last = cnt[END_BIT];

    srm_recode u_rec (
        .prev_bit (prev),
        .cur_bit  (rq[0]),
        .op       (op)
    );

    srm_step #(.W(W)) u_step (
        .acc      (acc),
        .rq       (rq),
        .mcand    (mcand),
        .op       (op),
        .shift_en (!last),
        .acc_nx   (acc_n),
        .rq_nx    (rq_n),
        .prev_nx  (prev_n)
    );

    // Next-state logic
    always_comb begin
        st_nx = st;
        unique case (st)
            S_IDLE:  if (start) st_nx = S_SCAN;                    // T_START
            S_SCAN: begin
                if (op != OP_NONE)  st_nx = S_FETCH;               // T_NEED
                else if (last)      st_nx = S_DONE;                // T_FINISH
                else                st_nx = S_SCAN;                // T_SKIP
            end
            S_FETCH: begin
                if (mcand_valid) st_nx = last ? S_DONE : S_SCAN;   // T_FINISH / T_APPLY
                else             st_nx = S_FETCH;                  // T_STALL
            end
            S_DONE:  st_nx = S_IDLE;                               // T_RETURN
            default: st_nx = S_IDLE;
        endcase
    end

    assign apply = ((st == S_SCAN) && (op == OP_NONE)) ||
                   ((st == S_FETCH) && mcand_valid);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= S_IDLE;
        else        st <= st_nx;
    end

    // Datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc  <= '0;
            rq   <= '0;
            cnt  <= '0;
            prev <= 1'b0;
        end else if ((st == S_IDLE) && start) begin
            acc  <= '0;
            rq   <= mult_in;
            cnt  <= count_in;
            prev <= 1'b0;
        end else if (apply) begin
            acc <= acc_n;
            rq  <= rq_n;
            if (!last) begin
                prev <= prev_n;
                cnt  <= cnt + CW'(1);
            end
        end
    end

    // Outputs
    always_comb begin
        op_req  = (st == S_FETCH);
        done    = (st == S_DONE);
        acc_out = acc;
        rq_out  = rq;
    end

endmodule

// File: rtl/srm_mul_chk.sv
module srm_mul_chk
    import srm_pkg::*;
#(
    parameter int W  = 32,
    parameter int CW = 6
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start,
    input logic [W-1:0]  mult_in,
    input logic          mcand_valid,
    input logic          op_req,
    input logic          done,
    input logic [W-1:0]  acc_out,
    input logic [W-1:0]  rq_out,
    input srm_state_t    st,
    input logic          prev,
    input logic [CW-1:0] cnt
);

    localparam int END_BIT = CW - 1;

    assert_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_IDLE && start) |=>
            (acc_out == '0 && rq_out == $past(mult_in) && !prev && st == S_SCAN));

    assert_skip_noreq_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_SCAN && prev == rq_out[0]) |=> !op_req);

    assert_need_req_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_SCAN && prev != rq_out[0]) |=> op_req);

    assert_stall_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (op_req && !mcand_valid) |=>
            (op_req && $stable(acc_out) && $stable(rq_out)));

    assert_skip_shift_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_SCAN && prev == rq_out[0] && !cnt[END_BIT]) |=>
            (acc_out == $past({acc_out[W-1], acc_out[W-1:1]}) &&
             rq_out  == $past({acc_out[0], rq_out[W-1:1]}) &&
             prev    == $past(rq_out[0])));

    assert_end_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_SCAN && prev == rq_out[0] && cnt[END_BIT]) |=> done);

    assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_done_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> ($stable(acc_out) && $stable(rq_out)));

endmodule

bind srm_mul srm_mul_chk #(.W(W), .CW(CW)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start),
    .mult_in     (mult_in),
    .mcand_valid (mcand_valid),
    .op_req      (op_req),
    .done        (done),
    .acc_out     (acc_out),
    .rq_out      (rq_out),
    .st          (st),
    .prev        (prev),
    .cnt         (cnt)
);

// File: tb/srm_mul_test.sv
`timescale 1ns/1ps
module srm_mul_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [31:0] mult_in = '0;
    logic [5:0]  count_in = '0;
    logic [31:0] mcand = '0;
    logic        mcand_valid = 1'b0;
    logic        op_req, done;
    logic [31:0] acc_out, rq_out;

    int tests = 0;
    int fails = 0;
    int stall_n = 0;
    int wait_n = 0;
    int fetches = 0;

    always #4 clk = ~clk;

    srm_mul uut (
        .clk(clk), .rst_n(rst_n), .start(start), .mult_in(mult_in),
        .count_in(count_in), .mcand(mcand), .mcand_valid(mcand_valid),
        .op_req(op_req), .acc_out(acc_out), .rq_out(rq_out), .done(done)
    );

    localparam int NV = 8;
    localparam logic [31:0] V_R [NV] = '{32'h0000_0003, 32'hFFFF_FFFF, 32'h8000_0000,
        32'h7FFF_FFFF, 32'h1234_5678, 32'h0000_00AB, 32'hFFFF_8001, 32'h0000_0003};
    localparam logic [31:0] V_M [NV] = '{32'h0000_0005, 32'h0000_0007, 32'h0000_0003,
        32'h7FFF_FFFF, 32'hFFFF_F000, 32'h0000_0064, 32'h7FFF_1234, 32'h0000_0009};
    localparam logic [5:0]  V_C [NV] = '{6'd1, 6'd1, 6'd1, 6'd1, 6'd1, 6'd25, 6'd17, 6'd40};

    // Store responder: raises valid after stall_n clocks of request
    initial forever begin
        @(negedge clk);
        if (op_req && !mcand_valid) begin
            if (wait_n >= stall_n) begin
                mcand_valid = 1'b1;
                wait_n = 0;
                fetches++;
            end else wait_n++;
        end else mcand_valid = 1'b0;
    end

    initial begin
        #(8 * 200000);
        fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic int n_of(input logic [5:0] c);
        return c[5] ? 1 : 33 - int'(c);
    endfunction

    function automatic void model(input logic [31:0] r, input logic [5:0] c, input logic [31:0] m,
                                  output logic [31:0] ea, output logic [31:0] er, output int ef);
        int n;
        logic [63:0] tmp;
        logic signed [63:0] rs, p;
        logic pv;
        n   = n_of(c);
        tmp = {32'b0, r} << (64 - n);
        rs  = $signed(tmp) >>> (64 - n);
        p   = $signed({{32{m[31]}}, m}) * rs;
        ea  = 32'(p >>> (n - 1));
        er  = 32'(p << (33 - n)) | (r >> (n - 1));
        ef  = 0;
        pv  = 1'b0;
        for (int i = 0; i < n; i++) begin
            if (pv != r[i]) ef++;
            pv = r[i];
        end
    endfunction

    task automatic run(input logic [31:0] r, input logic [5:0] c, input logic [31:0] m,
                       input int stl, input int poke, input string tag);
        logic [31:0] ea, er;
        int ef, lat;
        model(r, c, m, ea, er, ef);
        mcand = m;
        stall_n = stl;
        fetches = 0;
        @(negedge clk);
        mult_in = r; count_in = c; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        mult_in = ~r;              // R2: must be ignored after start
        count_in = c ^ 6'h1F;
        lat = 0;
        for (int k = 1; k <= 600; k++) begin
            @(negedge clk);
            if (k == poke) begin start = 1'b1; mult_in = 32'hDEAD_BEEF; count_in = 6'd32; end
            else start = 1'b0;
            if (done) begin lat = k; break; end
        end
        start = 1'b0;
        check(lat != 0, {tag, " R10 done seen"}, 64'(lat), 64'd1);
        check(acc_out == ea, {tag, " R8 acc"}, 64'(acc_out), 64'(ea));
        check(rq_out == er, {tag, " R8 rq"}, 64'(rq_out), 64'(er));
        check(fetches == ef, {tag, " R4 fetch count"}, 64'(fetches), 64'(ef));
        check(lat == n_of(c) + ef * (1 + stl), {tag, " R4 R5 run length"},
              64'(lat), 64'(n_of(c) + ef * (1 + stl)));
        @(negedge clk);
        check(!done && acc_out == ea && rq_out == er, {tag, " R10 pulse and hold"},
              {acc_out, rq_out}, {ea, er});
    endtask

    initial begin
        logic [31:0] rr, mm;
        logic [5:0]  cc;
        repeat (3) @(negedge clk);
        // R1 reset state
        check(acc_out == 0 && rq_out == 0 && !done && !op_req, "R1 reset",
              {acc_out, rq_out}, 64'd0);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++)
            run(V_R[i], V_C[i], V_M[i], i % 3, 0, "R7 table");

        // R3: single step subtract (pair 0,1) and no-op (pair 0,0)
        run(32'h0000_0001, 6'd32, 32'h0000_0009, 0, 0, "R3 sub");
        run(32'h0000_0002, 6'd32, 32'h0000_0009, 0, 0, "R3 none");
        // R3: add step reached through (1,0) with n=2
        run(32'h0000_0001, 6'd31, 32'h0000_0011, 1, 0, "R3 add");
        // R4: no requests when multiplier is zero, n=32 and n=5
        run(32'h0000_0000, 6'd1, 32'h1111_1111, 0, 0, "R4 zero32");
        run(32'h0000_0000, 6'd28, 32'h1111_1111, 0, 0, "R4 zero5");
        // R4: alternating bits request every step
        run(32'h5555_5555, 6'd1, 32'h0000_1234, 0, 0, "R4 alt");
        // R5: long stalls
        run(32'hF0F0_0F0F, 6'd1, 32'hFFFF_FFFE, 4, 0, "R5 stall");
        // R6 and R7: negative times negative
        run(32'hFFFF_FFF9, 6'd1, 32'hFFFF_FFFD, 0, 0, "R6 negneg");
        // R9: count with bit 5 set
        run(32'h0000_0003, 6'd63, 32'h0000_0021, 0, 0, "R9 count63");
        // R11: start pulsed mid-run
        run(32'h0F0F_1234, 6'd1, 32'h0000_0777, 1, 5, "R11 restart");

        for (int i = 0; i < 40; i++) begin
            rr = $urandom;
            mm = $urandom;
            if (mm == 32'h8000_0000) mm = 32'h8000_0001;
            cc = (i < 25) ? 6'd1 : 6'(1 + ($urandom % 32));
            run(rr, cc, mm, i % 2, 0, "R8 random");
        end

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule